// File: doc/BRIEF.md
# Switch Register Access Bridge

This block lets a host processor reach the paged configuration registers inside an Ethernet switch core through a small 32-bit memory-mapped register window. The host first asks for ownership of the switch access path by setting a request bit and waiting for a grant. Only then may it post a command that names a page and a register offset and starts a read or a write. The command's go bit stays set until the switch side acknowledges the access, and the host polls that bit to learn when the access has finished. Write data is supplied, and read data is returned, as a high and a low 32-bit word that together form a 64-bit value.

A second on-chip requester competes with the host for the access path. A fixed-priority arbiter decides between them and never takes a grant away in the middle of an access. Single-cycle event pulses from the switch are kept in a capture register that the host clears by writing ones. An interrupt line to the host is raised while any captured bit is set and the host has enabled interrupts.

Top module: `swreg_bridge`

## Requirements
- R1: After synchronous reset, every host-visible register reads zero except the init-done status, `sw_req` is low, neither grant is active and `host_irq` is low.
- R2: Bit 3 of the control word at 0x40 is the host request and bit 4 reads back the host grant. From the idle state the internal requester wins when both request together. A holder keeps the grant until it withdraws its request, and the grant then passes on one cycle later.
- R3: While a host command is busy, the host grant is not withdrawn, even if the host clears its request. The internal requester is not granted until that command completes.
- R4: Writing the command word at 0x2C with bit 0 (go) set, while the host holds the grant and no command is busy, starts an access on the next cycle. `sw_req` rises with page = bits 31:24, offset = bits 23:16 and write flag = bit 1. These stay stable until acknowledged, and the command word reads back with bit 0 set.
- R5: A go command is ignored when the host has no grant, or when a command is already busy. The busy bit and the switch-side request are left unchanged.
- R6: An acknowledge from the switch while `sw_req` is high clears busy and `sw_req` on the next cycle, after which bit 0 of the command word reads 0.
- R7: The write-data high word is at 0x30 and the low word at 0x34, and `sw_wdata` presents {high, low}. Writes to these words while a command is busy are ignored.
- R8: The read-data high word is at 0x38 and the low word at 0x3C. They load from `sw_rdata` only when a read access is acknowledged. A write acknowledge, or an acknowledge with no access pending, leaves them unchanged.
- R9: Writing the command word with bit 2 set aborts any pending access. Busy clears, `sw_req` drops, a go bit written in the same word is ignored, and bit 2 always reads 0.
- R10: The capture word at 0x44 sets bit i (i = 0 to 12) when `sw_evt[i]` pulses and holds it. Writing 1 to a bit clears it, and writing 0 leaves it alone.
- R11: When an event pulse and a clear for the same bit fall in the same cycle, the bit stays set.
- R12: `host_irq` is high exactly when bit 1 of the control word (interrupt enable) is set and at least one captured bit is set.
- R13: Bit 6 of the control word reflects the `sw_init_done` input, and bits 4 and 6 ignore host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_wr | input | 1 | Host write strobe, one cycle per write |
| hb_addr | input | ADDR_W | Host byte address for reads and writes |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data for `hb_addr` (combinational) |
| host_irq | output | 1 | Interrupt to the host |
| aux_req | input | 1 | Request from the internal requester |
| aux_gnt | output | 1 | Grant to the internal requester |
| sw_init_done | input | 1 | Switch initialisation finished |
| sw_evt | input | N_EVT | Single-cycle event pulses from the switch |
| sw_req | output | 1 | Switch access request, held until acknowledged |
| sw_we | output | 1 | Access is a write |
| sw_page | output | 8 | Register page |
| sw_reg | output | 8 | Register offset within the page |
| sw_wdata | output | 64 | Write data to the switch |
| sw_ack | input | 1 | Switch access acknowledge |
| sw_rdata | input | 64 | Read data from the switch, valid with `sw_ack` |

## Verification
Several properties are checked on every cycle: the two grants are never active together, the internal requester wins from idle, the host grant survives for as long as a command is busy, and a command can only begin under a host grant. The switch-side request and its fields stay put until acknowledged or aborted, read data moves only on a read acknowledge, each event bit is set the cycle after its pulse, and the interrupt never rises without a new event or a newly set enable. What the per-cycle properties cannot show is the register map itself. The directed scenarios therefore cover field positions in the command word, the {high, low} word order, rejected commands without grant or while busy, the abort path, the handing over of the grant after a busy command, and clearing by writing ones.

// File: rtl/swb_pkg.sv
// Shared constants and types for the switch register access bridge.
// Assumes a 32-bit host word; the switch-side data path is two host words.
package swb_pkg;
    localparam int HW  = 32;
    localparam int DW  = 2 * HW;
    localparam int PGW = 8;
    localparam int RGW = 8;

    // Host-visible word offsets
    localparam logic [7:0] A_CMD = 8'h2C;
    localparam logic [7:0] A_WDH = 8'h30;
    localparam logic [7:0] A_WDL = 8'h34;
    localparam logic [7:0] A_RDH = 8'h38;
    localparam logic [7:0] A_RDL = 8'h3C;
    localparam logic [7:0] A_CTL = 8'h40;
    localparam logic [7:0] A_EVT = 8'h44;

    // Command word fields
    localparam int CB_GO     = 0;
    localparam int CB_WR     = 1;
    localparam int CB_ABORT  = 2;
    localparam int CB_OFS_LO = 16;
    localparam int CB_PG_LO  = 24;

    // Control word fields
    localparam int KB_IEN  = 1;
    localparam int KB_REQ  = 3;
    localparam int KB_GNT  = 4;
    localparam int KB_INIT = 6;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_AUX  = 2'd2
    } owner_e;
endpackage

// File: rtl/swb_arbiter.sv
// Fixed-priority owner arbiter for the switch access path.
// The internal requester wins from idle; an owner keeps the path until it
// drops its request, and the host additionally keeps it while busy.
module swb_arbiter
    import swb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic aux_req,
    input  logic busy,
    output logic host_gnt,
    output logic aux_gnt
);
    owner_e own_q;
    owner_e own_d;

    // Next owner selection
    always_comb begin
        own_d = own_q;
        unique case (own_q)
            OWN_NONE: begin
                if (aux_req)       own_d = OWN_AUX;
                else if (host_req) own_d = OWN_HOST;
            end
            OWN_HOST: if (!host_req && !busy) own_d = OWN_NONE;
            OWN_AUX:  if (!aux_req)           own_d = OWN_NONE;
            default:  own_d = OWN_NONE;
        endcase
    end

    // Owner register
    always_ff @(posedge clk) begin
        if (!rst_n) own_q <= OWN_NONE;
        else        own_q <= own_d;
    end

    assign host_gnt = (own_q == OWN_HOST);
    assign aux_gnt  = (own_q == OWN_AUX);

    p_excl_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_gnt && aux_gnt));
    p_aux_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_gnt && !aux_gnt && aux_req) |=> aux_gnt);
    p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && busy) |=> host_gnt);
endmodule

// File: rtl/swb_cmd_engine.sv
// Command engine: holds write/read data words, launches one switch access
// per accepted go command, and retires it on acknowledge or abort.
// Assumes the switch holds sw_rdata valid in the acknowledge cycle.
module swb_cmd_engine
    import swb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_wr,
    input  logic           wdh_wr,
    input  logic           wdl_wr,
    input  logic [HW-1:0]  wdata,
    input  logic           host_gnt,
    output logic           busy,
    output logic           wr_flag,
    output logic [PGW-1:0] page,
    output logic [RGW-1:0] ofs,
    output logic [HW-1:0]  wd_hi,
    output logic [HW-1:0]  wd_lo,
    output logic [HW-1:0]  rd_hi,
    output logic [HW-1:0]  rd_lo,
    output logic           sw_req,
    output logic           sw_we,
    output logic [PGW-1:0] sw_page,
    output logic [RGW-1:0] sw_reg,
    output logic [DW-1:0]  sw_wdata,
    input  logic           sw_ack,
    input  logic [DW-1:0]  sw_rdata
);
    logic           busy_q;
    logic           we_q;
    logic [PGW-1:0] page_q;
    logic [RGW-1:0] ofs_q;
    logic [HW-1:0]  wdh_q, wdl_q, rdh_q, rdl_q;
    logic           abort, launch, done;

    assign abort  = cmd_wr && wdata[CB_ABORT];
    assign launch = cmd_wr && wdata[CB_GO] && !wdata[CB_ABORT] && host_gnt && !busy_q;
    assign done   = busy_q && sw_ack && !abort;

    // Busy flag: abort beats launch beats completion
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (abort)  busy_q <= 1'b0;
        else if (launch) busy_q <= 1'b1;
        else if (done)   busy_q <= 1'b0;
    end

    // Command fields captured on an accepted launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            page_q <= '0;
            ofs_q  <= '0;
        end else if (launch) begin
            we_q   <= wdata[CB_WR];
            page_q <= wdata[CB_PG_LO +: PGW];
            ofs_q  <= wdata[CB_OFS_LO +: RGW];
        end
    end

    // Write-data words, frozen while an access is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdh_q <= '0;
            wdl_q <= '0;
        end else if (!busy_q) begin
            if (wdh_wr) wdh_q <= wdata;
            if (wdl_wr) wdl_q <= wdata;
        end
    end

    // Read-data words, loaded only by a read acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdh_q <= '0;
            rdl_q <= '0;
        end else if (done && !we_q) begin
            rdh_q <= sw_rdata[DW-1:HW];
            rdl_q <= sw_rdata[HW-1:0];
        end
    end

    assign busy     = busy_q;
    assign wr_flag  = we_q;
    assign page     = page_q;
    assign ofs      = ofs_q;
    assign wd_hi    = wdh_q;
    assign wd_lo    = wdl_q;
    assign rd_hi    = rdh_q;
    assign rd_lo    = rdl_q;
    assign sw_req   = busy_q;
    assign sw_we    = we_q;
    assign sw_page  = page_q;
    assign sw_reg   = ofs_q;
    assign sw_wdata = {wdh_q, wdl_q};

    p_launch_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(host_gnt));
    p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !sw_ack && !abort) |=>
            (sw_req && $stable(sw_page) && $stable(sw_reg) && $stable(sw_we) && $stable(sw_wdata)));
    p_ack_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && sw_ack) |=> !sw_req);
    p_rd_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rdh_q, rdl_q}) |-> $past(sw_req && sw_ack && !sw_we));
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !sw_req);
endmodule

// File: rtl/swb_irq_capture.sv
// Event capture: one sticky bit per switch event line, cleared by writing
// ones; a pulse in the same cycle as a clear keeps the bit set.
module swb_irq_capture #(
    parameter int N_EVT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic             clr_wr,
    input  logic [N_EVT-1:0] clr_mask,
    output logic [N_EVT-1:0] cap
);
    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        logic bit_q;

        // Sticky capture with set priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)                      bit_q <= 1'b0;
            else if (evt[i])                 bit_q <= 1'b1;
            else if (clr_wr && clr_mask[i])  bit_q <= 1'b0;
        end

        assign cap[i] = bit_q;

        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> cap[i]);
        p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_mask[i] && !evt[i]) |=> !cap[i]);
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[i] && !(clr_wr && clr_mask[i])) |=> $stable(cap[i]));
    end
endmodule

// File: rtl/swreg_bridge.sv
// Top of the switch register access bridge: host register decode and read
// mux, control word, and the three sub-blocks. Assumes word-aligned host
// addresses, single-cycle write strobes and N_EVT no larger than 32.
module swreg_bridge
    import swb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_EVT  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_wr,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic [HW-1:0]     hb_wdata,
    output logic [HW-1:0]     hb_rdata,
    output logic              host_irq,
    input  logic              aux_req,
    output logic              aux_gnt,
    input  logic              sw_init_done,
    input  logic [N_EVT-1:0]  sw_evt,
    output logic              sw_req,
    output logic              sw_we,
    output logic [PGW-1:0]    sw_page,
    output logic [RGW-1:0]    sw_reg,
    output logic [DW-1:0]     sw_wdata,
    input  logic              sw_ack,
    input  logic [DW-1:0]     sw_rdata
);
    logic           hit_cmd, hit_wdh, hit_wdl, hit_ctl, hit_evt;
    logic           ien_q, req_q;
    logic           host_gnt, busy, wr_flag;
    logic [PGW-1:0] page;
    logic [RGW-1:0] ofs;
    logic [HW-1:0]  wd_hi, wd_lo, rd_hi, rd_lo;
    logic [N_EVT-1:0] cap;

    assign hit_cmd = hb_wr && (hb_addr == ADDR_W'(A_CMD));
    assign hit_wdh = hb_wr && (hb_addr == ADDR_W'(A_WDH));
    assign hit_wdl = hb_wr && (hb_addr == ADDR_W'(A_WDL));
    assign hit_ctl = hb_wr && (hb_addr == ADDR_W'(A_CTL));
    assign hit_evt = hb_wr && (hb_addr == ADDR_W'(A_EVT));

    // Host-writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
            req_q <= 1'b0;
        end else if (hit_ctl) begin
            ien_q <= hb_wdata[KB_IEN];
            req_q <= hb_wdata[KB_REQ];
        end
    end

    swb_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_req (req_q),
        .aux_req  (aux_req),
        .busy     (busy),
        .host_gnt (host_gnt),
        .aux_gnt  (aux_gnt)
    );

    swb_cmd_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (hit_cmd),
        .wdh_wr   (hit_wdh),
        .wdl_wr   (hit_wdl),
        .wdata    (hb_wdata),
        .host_gnt (host_gnt),
        .busy     (busy),
        .wr_flag  (wr_flag),
        .page     (page),
        .ofs      (ofs),
        .wd_hi    (wd_hi),
        .wd_lo    (wd_lo),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo),
        .sw_req   (sw_req),
        .sw_we    (sw_we),
        .sw_page  (sw_page),
        .sw_reg   (sw_reg),
        .sw_wdata (sw_wdata),
        .sw_ack   (sw_ack),
        .sw_rdata (sw_rdata)
    );

    swb_irq_capture #(.N_EVT(N_EVT)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (sw_evt),
        .clr_wr   (hit_evt),
        .clr_mask (hb_wdata[N_EVT-1:0]),
        .cap      (cap)
    );

    // Host read mux
    always_comb begin
        hb_rdata = '0;
        case (hb_addr)
            ADDR_W'(A_CMD): begin
                hb_rdata[CB_PG_LO +: PGW]  = page;
                hb_rdata[CB_OFS_LO +: RGW] = ofs;
                hb_rdata[CB_WR]            = wr_flag;
                hb_rdata[CB_GO]            = busy;
            end
            ADDR_W'(A_WDH): hb_rdata = wd_hi;
            ADDR_W'(A_WDL): hb_rdata = wd_lo;
            ADDR_W'(A_RDH): hb_rdata = rd_hi;
            ADDR_W'(A_RDL): hb_rdata = rd_lo;
            ADDR_W'(A_CTL): begin
                hb_rdata[KB_IEN]  = ien_q;
                hb_rdata[KB_REQ]  = req_q;
                hb_rdata[KB_GNT]  = host_gnt;
                hb_rdata[KB_INIT] = sw_init_done;
            end
            ADDR_W'(A_EVT): hb_rdata[N_EVT-1:0] = cap;
            default: hb_rdata = '0;
        endcase
    end

    assign host_irq = ien_q && (|cap);

    p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> ($past(sw_evt != '0) || $rose(ien_q)));
    p_irq_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ctl && !hb_wdata[KB_IEN]) |=> !host_irq);
endmodule

// File: tb/swreg_bridge_tb_top.sv
`timescale 1ns/1ps
module swreg_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_wr = 1'b0;
    logic [7:0]  hb_addr = 8'h00;
    logic [31:0] hb_wdata = '0;
    logic [31:0] hb_rdata;
    logic        host_irq;
    logic        aux_req = 1'b0;
    logic        aux_gnt;
    logic        sw_init_done = 1'b0;
    logic [12:0] sw_evt = '0;
    logic        sw_req, sw_we;
    logic [7:0]  sw_page, sw_reg;
    logic [63:0] sw_wdata;
    logic        sw_ack = 1'b0;
    logic [63:0] sw_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    swreg_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .host_irq(host_irq),
        .aux_req(aux_req), .aux_gnt(aux_gnt), .sw_init_done(sw_init_done),
        .sw_evt(sw_evt), .sw_req(sw_req), .sw_we(sw_we), .sw_page(sw_page),
        .sw_reg(sw_reg), .sw_wdata(sw_wdata), .sw_ack(sw_ack), .sw_rdata(sw_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
        @(negedge clk);
        hb_wr = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [31:0] d);
        hb_addr = a;
        #1;
        d = hb_rdata;
    endtask

    task automatic ack_pulse();
        @(negedge clk); sw_ack = 1'b1;
        @(negedge clk); sw_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hr(8'h40, v); chk("R1 ctl", v, 0);
        hr(8'h2C, v); chk("R1 cmd", v, 0);
        hr(8'h44, v); chk("R1 evt", v, 0);
        hr(8'h38, v); chk("R1 rdh", v, 0);
        chk("R1 sw_req/irq/gnt", {sw_req, host_irq, aux_gnt}, 0);
        sw_init_done = 1'b1;
        hw(8'h40, 32'h0000_0050);
        hr(8'h40, v); chk("R13 init bit, ro bits", v, 32'h40);
    endtask

    task automatic t_nogrant();
        logic [31:0] v;
        hw(8'h2C, 32'h1234_0001);
        @(negedge clk);
        chk("R5 no grant sw_req", sw_req, 0);
        hr(8'h2C, v); chk("R5 no grant cmd", v, 0);
    endtask

    task automatic t_grant();
        logic [31:0] v;
        hw(8'h40, 32'h08);
        @(negedge clk);
        hr(8'h40, v); chk("R2 host grant", v, 32'h58);
    endtask

    task automatic t_write();
        logic [31:0] v;
        hw(8'h30, 32'hAABB_CCDD);
        hw(8'h34, 32'h1122_3344);
        hw(8'h2C, 32'h050A_0003);
        chk("R4 req", {sw_req, sw_we, sw_page, sw_reg}, {1'b1, 1'b1, 8'h05, 8'h0A});
        chk("R7 wdata order", sw_wdata, 64'hAABBCCDD11223344);
        hr(8'h2C, v); chk("R4 cmd busy", v, 32'h050A_0003);
        hw(8'h34, 32'hFFFF_FFFF);
        chk("R7 frozen while busy", sw_wdata, 64'hAABBCCDD11223344);
        ack_pulse();
        chk("R6 req dropped", sw_req, 0);
        hr(8'h2C, v); chk("R6 go cleared", v, 32'h050A_0002);
        hr(8'h3C, v); chk("R8 write ack no load", v, 0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        sw_rdata = 64'h0123_4567_89AB_CDEF;
        hw(8'h2C, 32'h0710_0001);
        chk("R4 read req", {sw_req, sw_we, sw_page, sw_reg}, {1'b1, 1'b0, 8'h07, 8'h10});
        hr(8'h3C, v); chk("R8 no load before ack", v, 0);
        hw(8'h2C, 32'h0920_0001);
        chk("R5 go while busy", {sw_req, sw_page}, {1'b1, 8'h07});
        ack_pulse();
        hr(8'h38, v); chk("R8 rd high", v, 32'h0123_4567);
        hr(8'h3C, v); chk("R8 rd low", v, 32'h89AB_CDEF);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        hw(8'h2C, 32'h0304_0001);
        chk("R9 launched", sw_req, 1);
        hw(8'h2C, 32'h0000_0005);
        chk("R9 aborted", sw_req, 0);
        hr(8'h2C, v); chk("R9 cmd readback", v, 32'h0304_0000);
        sw_rdata = 64'hDEAD_BEEF_0BAD_F00D;
        ack_pulse();
        hr(8'h3C, v); chk("R8 idle ack ignored", v, 32'h89AB_CDEF);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        hw(8'h2C, 32'h0102_0001);
        hw(8'h40, 32'h00);
        aux_req = 1'b1;
        repeat (2) @(negedge clk);
        hr(8'h40, v); chk("R3 grant kept while busy", v, 32'h50);
        chk("R3 aux waits", aux_gnt, 0);
        ack_pulse();
        repeat (2) @(negedge clk);
        chk("R3 aux after done", aux_gnt, 1);
        hr(8'h40, v); chk("R2 host released", v, 32'h40);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        hw(8'h40, 32'h08);
        repeat (2) @(negedge clk);
        hr(8'h40, v); chk("R2 aux holds", v, 32'h48);
        @(negedge clk); aux_req = 1'b0;
        @(negedge clk); aux_req = 1'b1;
        @(negedge clk);
        chk("R2 aux wins from idle", aux_gnt, 1);
        hr(8'h40, v); chk("R2 host loses", v, 32'h48);
        aux_req = 1'b0;
        repeat (2) @(negedge clk);
        hr(8'h40, v); chk("R2 host after aux", v, 32'h58);
        hw(8'h40, 32'h00);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); sw_evt = 13'h1201;
        @(negedge clk); sw_evt = '0;
        hr(8'h44, v); chk("R10 capture", v, 32'h1201);
        chk("R12 masked", host_irq, 0);
        hw(8'h40, 32'h02);
        chk("R12 enabled", host_irq, 1);
        hw(8'h44, 32'h0000_0001);
        hr(8'h44, v); chk("R10 w1c", v, 32'h1200);
        @(negedge clk);
        hb_wr = 1'b1; hb_addr = 8'h44; hb_wdata = 32'h1000; sw_evt = 13'h1000;
        @(negedge clk);
        hb_wr = 1'b0; sw_evt = '0;
        hr(8'h44, v); chk("R11 set wins", v, 32'h1200);
        hw(8'h44, 32'hFFFF_FFFF);
        hr(8'h44, v); chk("R10 clear all", v, 0);
        chk("R12 irq low", host_irq, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_nogrant();
        t_grant();
        t_write();
        t_read();
        t_abort();
        t_hold();
        t_prio();
        t_irq();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule